// File: doc/BRIEF.md
# UART Transmit and Flow-Control Status Flags with Interrupt Combiner

This block keeps four status bits of a serial port and turns them into one interrupt request. It holds a live clear-to-send level and a sticky clear-to-send change flag. It also holds a sticky line-break flag and a transmit-buffer-empty flag. Each flag has its own interrupt enable. The interrupt line is the registered OR of every flag whose enable is set.

The raw active-low clear-to-send pin enters a two-stage synchronizer. A change of the synchronized level, in either direction, sets the change flag, but only while flow control is enabled. The change flag is cleared by writing 1 to its bit of a write-one-to-clear vector. The line-break flag works the same way: a pulse from an external break detector sets it. The transmit-empty flag is a two-state machine. Its states are `TX_VACANT` (flag reads 1) and `TX_HELD` (flag reads 0). Reset enters `TX_VACANT`. A data-register write takes it from `TX_VACANT` to `TX_HELD`. A transfer to the shift register, or a flush request, takes it from `TX_HELD` back to `TX_VACANT`. A flush discards any pending data. In every sticky flag and in the state machine, a hardware set event wins over a clear in the same cycle.

Top module: `uart_flag_irq`

## Requirements
- R1: `cts_lvl` is the inverse of `cts_n_pin`, delayed by two clock edges. After reset it reads 0.
- R2: While `flow_en` is 1, any change of the synchronized pin level, rising or falling, sets `cts_chg_flag`. The flag reads 1 three clock edges after the pin changes.
- R3: While `flow_en` is 0, changes of the pin level leave `cts_chg_flag` unchanged.
- R4: Writing `flag_clr[0]`=1 clears `cts_chg_flag` at the next edge. `flag_clr[1]` has no effect on it.
- R5: A `brk_det` pulse sets `brk_flag` at the next edge. Writing `flag_clr[1]`=1 clears it, and `flag_clr[0]` has no effect on it.
- R6: In a cycle where a sticky flag has both a set event and its clear bit, the flag ends up set.
- R7: After reset, `txe_flag` reads 1 (`TX_VACANT`). A `tdr_wr` strobe makes it 0 at the next edge (`TX_HELD`).
- R8: A `shift_load` pulse makes `txe_flag` 1 at the next edge.
- R9: A `tx_flush` pulse makes `txe_flag` 1 at the next edge.
- R10: When `tdr_wr` comes in the same cycle as `shift_load` or `tx_flush`, `txe_flag` ends up 1.
- R11: `irq` equals, one edge later, the OR of the flag-and-enable terms. The enable bits are `irq_en[0]` for transmit-empty, `irq_en[1]` for clear-to-send change and `irq_en[2]` for line break. After reset `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Raw active-low clear-to-send pin |
| flow_en | input | 1 | Enables detection of clear-to-send changes |
| brk_det | input | 1 | One-cycle pulse from the line-break detector |
| tdr_wr | input | 1 | Transmit data register write strobe |
| shift_load | input | 1 | Data register moved into the shift register |
| tx_flush | input | 1 | Request to discard pending transmit data |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clear-to-send change, bit 1 line break |
| irq_en | input | 3 | Interrupt enables: bit 0 transmit-empty, bit 1 clear-to-send change, bit 2 line break |
| txe_flag | output | 1 | Transmit buffer empty |
| cts_lvl | output | 1 | Inverted synchronized clear-to-send level |
| cts_chg_flag | output | 1 | Sticky clear-to-send change flag |
| brk_flag | output | 1 | Sticky line-break flag |
| irq | output | 1 | Registered combined interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- The set-over-clear priority of both sticky flags.
- The `TX_VACANT`/`TX_HELD` transitions.
- The rule that the change flag only rises after a cycle with flow control enabled.
- The one-cycle relation between the enabled flags and `irq`.

Other behaviour can only be shown by the bench's scenarios:
- The exact synchronizer latency.
- Detection of both edge directions.
- The reset values.
- The bit position of each clear and enable.

The bench sweeps all eight flag combinations against all eight enable masks.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
    // Transmit buffer occupancy
    typedef enum logic {
        TX_HELD   = 1'b0,
        TX_VACANT = 1'b1
    } txbuf_state_t;

    // Interrupt enable / flag vector positions
    localparam int IRQ_TXE   = 0;
    localparam int IRQ_CTS   = 1;
    localparam int IRQ_BRK   = 2;
    localparam int NUM_IRQ   = 3;

    // Write-one-to-clear positions (sticky flags)
    localparam int CLR_CTS   = 0;
    localparam int CLR_BRK   = 1;
    localparam int NUM_STICKY = 2;
endpackage

// File: rtl/uart_cts_watch.sv
module uart_cts_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_pin,
    input  logic flow_en,
    output logic cts_lvl,
    output logic cts_toggle
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    // Synchronizer chain plus one sample of history; idle pin level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[MSB-1:0], cts_n_pin};
            prev_q <= sync_q[MSB];
        end
    end

    always_comb begin
        cts_lvl    = ~sync_q[MSB];
        cts_toggle = flow_en && (sync_q[MSB] != prev_q);
    end

    // R2
    cts_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !cts_toggle) |-> $stable(cts_lvl));
endmodule

// File: rtl/uart_sticky_flag.sv
module uart_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/uart_txe_fsm.sv
module uart_txe_fsm
    import uart_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tdr_wr,
    input  logic shift_load,
    input  logic tx_flush,
    output logic txe_o
);
    txbuf_state_t state_q, state_d;
    logic         drain;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_VACANT;
        else
            state_q <= state_d;
    end

    // Next state and output
    always_comb begin
        drain   = shift_load || tx_flush;
        state_d = state_q;
        unique case (state_q)
            TX_VACANT: if (tdr_wr && !drain) state_d = TX_HELD;
            TX_HELD:   if (drain)            state_d = TX_VACANT;
            default:                         state_d = TX_VACANT;
        endcase
        txe_o = (state_q == TX_VACANT);
    end

    // R7
    held_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr && !shift_load && !tx_flush) |=> !txe_o);

    // R10
    vacant_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_load || tx_flush) |=> txe_o);
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
    import uart_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cts_n_pin,
    input  logic                  flow_en,
    input  logic                  brk_det,
    input  logic                  tdr_wr,
    input  logic                  shift_load,
    input  logic                  tx_flush,
    input  logic [NUM_STICKY-1:0] flag_clr,
    input  logic [NUM_IRQ-1:0]    irq_en,
    output logic                  txe_flag,
    output logic                  cts_lvl,
    output logic                  cts_chg_flag,
    output logic                  brk_flag,
    output logic                  irq
);
    logic                  cts_toggle;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky_q;
    logic [NUM_IRQ-1:0]    flag_vec;
    logic                  irq_d;

    uart_cts_watch #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_n_pin  (cts_n_pin),
        .flow_en    (flow_en),
        .cts_lvl    (cts_lvl),
        .cts_toggle (cts_toggle)
    );

    uart_txe_fsm u_txe (
        .clk        (clk),
        .rst_n      (rst_n),
        .tdr_wr     (tdr_wr),
        .shift_load (shift_load),
        .tx_flush   (tx_flush),
        .txe_o      (txe_flag)
    );

    always_comb begin
        sticky_set          = '0;
        sticky_set[CLR_CTS] = cts_toggle;
        sticky_set[CLR_BRK] = brk_det;
    end

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        uart_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (sticky_set[i]),
            .clr_i  (flag_clr[i]),
            .flag_o (sticky_q[i])
        );
    end

    always_comb begin
        cts_chg_flag      = sticky_q[CLR_CTS];
        brk_flag          = sticky_q[CLR_BRK];
        flag_vec          = '0;
        flag_vec[IRQ_TXE] = txe_flag;
        flag_vec[IRQ_CTS] = cts_chg_flag;
        flag_vec[IRQ_BRK] = brk_flag;
        irq_d             = |(flag_vec & irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= irq_d;
    end

    // R3
    cts_rise_needs_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_chg_flag) |-> $past(flow_en));

    // R11
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(flag_vec & irq_en) |=> irq);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_vec & irq_en)) |=> !irq);
endmodule

// File: tb/uart_flag_irq_test.sv
module uart_flag_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_pin = 1'b1;
    logic       flow_en = 1'b0;
    logic       brk_det = 1'b0;
    logic       tdr_wr = 1'b0;
    logic       shift_load = 1'b0;
    logic       tx_flush = 1'b0;
    logic [1:0] flag_clr = 2'b00;
    logic [2:0] irq_en = 3'b000;
    logic       txe_flag, cts_lvl, cts_chg_flag, brk_flag, irq;

    int n_checks = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    uart_flag_irq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_n_pin    (cts_n_pin),
        .flow_en      (flow_en),
        .brk_det      (brk_det),
        .tdr_wr       (tdr_wr),
        .shift_load   (shift_load),
        .tx_flush     (tx_flush),
        .flag_clr     (flag_clr),
        .irq_en       (irq_en),
        .txe_flag     (txe_flag),
        .cts_lvl      (cts_lvl),
        .cts_chg_flag (cts_chg_flag),
        .brk_flag     (brk_flag),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses_off();
        brk_det = 0; tdr_wr = 0; shift_load = 0; tx_flush = 0; flag_clr = 2'b00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        tick(3);
        // Reset values (R1, R7, R11)
        chk("R7 txe reset", txe_flag, 1'b1);
        chk("R1 lvl reset", cts_lvl, 1'b0);
        chk("R2 chg reset", cts_chg_flag, 1'b0);
        chk("R5 brk reset", brk_flag, 1'b0);
        chk("R11 irq reset", irq, 1'b0);
        rst_n = 1'b1;
        tick(2);
        chk("R2 no spurious change", cts_chg_flag, 1'b0);

        // Falling pin with flow control on (R1, R2)
        flow_en = 1; cts_n_pin = 0;
        tick(1);
        chk("R1 lvl after 1 edge", cts_lvl, 1'b0);
        tick(1);
        chk("R1 lvl after 2 edges", cts_lvl, 1'b1);
        chk("R2 chg after 2 edges", cts_chg_flag, 1'b0);
        tick(1);
        chk("R2 chg after 3 edges", cts_chg_flag, 1'b1);

        // Wrong clear bit, then right one (R4)
        flag_clr = 2'b10; tick(1); pulses_off();
        chk("R4 bit1 leaves chg", cts_chg_flag, 1'b1);
        flag_clr = 2'b01; tick(1); pulses_off();
        chk("R4 bit0 clears chg", cts_chg_flag, 1'b0);

        // Rising edge also detected (R2)
        cts_n_pin = 1; tick(3);
        chk("R2 rising edge sets chg", cts_chg_flag, 1'b1);
        chk("R1 lvl after rise", cts_lvl, 1'b0);
        flag_clr = 2'b01; tick(1); pulses_off();

        // Flow control off (R3)
        flow_en = 0; cts_n_pin = 0; tick(4);
        chk("R1 lvl tracks pin without flow", cts_lvl, 1'b1);
        chk("R3 no chg without flow", cts_chg_flag, 1'b0);
        cts_n_pin = 1; tick(4);
        chk("R3 no chg on rise without flow", cts_chg_flag, 1'b0);

        // Break flag (R5, R6)
        brk_det = 1; tick(1); pulses_off();
        chk("R5 brk set", brk_flag, 1'b1);
        flag_clr = 2'b01; tick(1); pulses_off();
        chk("R5 bit0 leaves brk", brk_flag, 1'b1);
        flag_clr = 2'b10; tick(1); pulses_off();
        chk("R5 bit1 clears brk", brk_flag, 1'b0);
        brk_det = 1; flag_clr = 2'b10; tick(1); pulses_off();
        chk("R6 set beats clear", brk_flag, 1'b1);
        flag_clr = 2'b10; tick(1); pulses_off();

        // Transmit-empty state machine (R7-R10)
        tdr_wr = 1; tick(1); pulses_off();
        chk("R7 write empties vacancy", txe_flag, 1'b0);
        shift_load = 1; tick(1); pulses_off();
        chk("R8 load sets txe", txe_flag, 1'b1);
        tdr_wr = 1; tick(1); pulses_off();
        tx_flush = 1; tick(1); pulses_off();
        chk("R9 flush sets txe", txe_flag, 1'b1);
        tdr_wr = 1; shift_load = 1; tick(1); pulses_off();
        chk("R10 write with load", txe_flag, 1'b1);
        tdr_wr = 1; tick(1); pulses_off();
        tdr_wr = 1; tx_flush = 1; tick(1); pulses_off();
        chk("R10 write with flush", txe_flag, 1'b1);

        // Interrupt sweep: all flag sets against all enable masks (R11)
        flow_en = 1;
        for (int f = 0; f < 8; f++) begin
            tdr_wr = 1; flag_clr = 2'b11; tick(1); pulses_off();
            if (f[1]) begin
                cts_n_pin = ~cts_n_pin; tick(3);
            end
            tx_flush = f[0]; brk_det = f[2]; tick(1); pulses_off();
            chk("R11 sweep txe state", txe_flag, f[0]);
            chk("R11 sweep chg state", cts_chg_flag, f[1]);
            chk("R11 sweep brk state", brk_flag, f[2]);
            for (int e = 0; e < 8; e++) begin
                irq_en = 3'(e);
                tick(1);
                chk("R11 irq combine", irq, |(3'(f) & 3'(e)));
            end
            irq_en = 3'b000;
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule